// File: doc/BRIEF.md
# Adjustable PTP Time Counter

This block keeps a free-running time of day in nanoseconds for network timestamping. On every clock tick it adds a fixed 8 ns step. It also adds a signed sub-nanosecond correction to a 32-bit fractional accumulator. When that accumulator carries out, the tick gains one nanosecond. When it borrows, the tick loses one. Software trims the counter's rate by setting the size and sign of the correction.

Software reaches the counter through a synchronous 32-bit register port. Reading the sub-nanosecond word also freezes the whole nanosecond count into a shadow copy. Later reads of the low and high nanosecond words return that frozen copy, so a read that spans several words stays consistent. To load a new time, software writes the low word, which is only staged, and then the high word, which commits the load.

Top module: `ptp_tod_counter`

## Requirements
- R1: With a zero correction, the nanosecond count grows by exactly 8 on every clock edge that is not a load.
- R2: With bit 31 of the rate word clear, bits 30:0 are added to the fractional word on every tick. A carry out of the fractional word adds one extra nanosecond to that tick.
- R3: With bit 31 of the rate word set, bits 30:0 are subtracted from the fractional word on every tick. A borrow takes one nanosecond away from that tick.
- R4: The nanosecond count is 40 bits wide and wraps modulo 2^40. A read of the high word (address 2) returns count bits 39:32 in bits 7:0, and bits 31:8 read as zero.
- R5: A read of address 0 returns the live fractional word and copies the live nanosecond count into a shadow. Reads of address 1 (shadow bits 31:0) and address 2 return the shadow, which stays unchanged until the next read of address 0.
- R6: A write to address 1 only stages its data. The running count is not disturbed.
- R7: A write to address 2 loads {wdata bits 7:0, staged low word} into the count at the edge that samples the write, and clears the fractional word. Counting resumes on the following edge.
- R8: A write to address 0 has no effect on the count or on the fractional word.
- R9: Address 3 holds the rate word. A write sets it, and a read returns it.
- R10: After reset, every word is zero: the count, the fractional word, the shadow, the staged low word and the rate word.
- R11: Read data appears on rdata_o in the cycle after the edge that samples the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one counter tick per edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe, sampled on the clock edge |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Word address: 0 fraction, 1 ns low, 2 ns high, 3 rate |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one cycle after the read request |

## Verification
A read request sampled at edge E returns its data after edge E, and the monitor compares it at the falling edge that follows. A load sampled at edge L shows the loaded value immediately, so a snapshot taken at edge E reflects E-1-L ticks of counting. The bench numbers every rising edge and stamps each request with the edge that will sample it. From that edge index it computes the expected count and fraction arithmetically from the loaded time, the step and the correction. Shadow reads that come many cycles after their snapshot must still return the value frozen at the snapshot edge.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int NS_W    = 40;
  localparam int REG_W   = 32;
  localparam int STEP_NS = 8;

  typedef enum logic [1:0] {
    ADR_FRAC = 2'd0,
    ADR_NSLO = 2'd1,
    ADR_NSHI = 2'd2,
    ADR_RATE = 2'd3
  } tod_addr_e;
endpackage

// File: rtl/tod_accum.sv
module tod_accum #(
  parameter int NS_W    = 40,
  parameter int FRAC_W  = 32,
  parameter int STEP_NS = 8,
  localparam int MAG_W  = FRAC_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [NS_W-1:0]   load_ns_i,
  input  logic [MAG_W-1:0]  mag_i,
  input  logic              neg_i,
  output logic [NS_W-1:0]   ns_o,
  output logic [FRAC_W-1:0] frac_o
);
  localparam logic [NS_W-1:0] STEP_V = NS_W'(STEP_NS);
  localparam logic [NS_W-1:0] ONE_V  = NS_W'(1);

  logic [NS_W-1:0]   ns_q, ns_d;
  logic [FRAC_W-1:0] frac_q, frac_d;
  logic [FRAC_W:0]   sum_w, dif_w;
  logic              up, dn;

  always_comb begin
    sum_w = {1'b0, frac_q} + {2'b00, mag_i};
    dif_w = {1'b0, frac_q} - {2'b00, mag_i};
    if (neg_i) begin
      frac_d = dif_w[FRAC_W-1:0];
      up     = 1'b0;
      dn     = dif_w[FRAC_W];
    end else begin
      frac_d = sum_w[FRAC_W-1:0];
      up     = sum_w[FRAC_W];
      dn     = 1'b0;
    end
    ns_d = ns_q + STEP_V + {{(NS_W-1){1'b0}}, up} - {{(NS_W-1){1'b0}}, dn};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ns_q   <= '0;
      frac_q <= '0;
    end else if (load_i) begin
      ns_q   <= load_ns_i;
      frac_q <= '0;
    end else begin
      ns_q   <= ns_d;
      frac_q <= frac_d;
    end
  end

  assign ns_o   = ns_o_w();
  assign frac_o = frac_q;

  function automatic logic [NS_W-1:0] ns_o_w();
    return ns_q;
  endfunction

  // R1
  step_nominal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && mag_i == '0) |=> (ns_q - $past(ns_q)) == STEP_V);

  // R2
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ((ns_q - $past(ns_q)) == STEP_V) ||
                ((ns_q - $past(ns_q)) == STEP_V + ONE_V) ||
                ((ns_q - $past(ns_q)) == STEP_V - ONE_V));

  // R3
  neg_no_gain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && neg_i) |=> (ns_q - $past(ns_q)) != STEP_V + ONE_V);

  // R7
  load_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ns_q == $past(load_ns_i));

  // R7
  load_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> frac_q == '0);
endmodule

// File: rtl/tod_shadow.sv
module tod_shadow #(
  parameter int NS_W  = 40,
  parameter int REG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             snap_en_i,
  input  logic [NS_W-1:0]  ns_i,
  input  logic             stage_en_i,
  input  logic [REG_W-1:0] stage_d_i,
  output logic [NS_W-1:0]  snap_o,
  output logic [REG_W-1:0] stage_o
);
  logic [NS_W-1:0]  snap_q;
  logic [REG_W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q  <= '0;
      stage_q <= '0;
    end else begin
      if (snap_en_i)  snap_q  <= ns_i;
      if (stage_en_i) stage_q <= stage_d_i;
    end
  end

  assign snap_o  = snap_q;
  assign stage_o = stage_q;

  // R5
  snap_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_en_i |=> snap_q == $past(ns_i));

  // R5
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_en_i |=> $stable(snap_q));

  // R6
  stage_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stage_en_i |=> $stable(stage_q));
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter #(
  parameter int NS_W    = tod_pkg::NS_W,
  parameter int REG_W   = tod_pkg::REG_W,
  parameter int STEP_NS = tod_pkg::STEP_NS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o
);
  import tod_pkg::*;

  localparam int FRAC_W = REG_W;
  localparam int MAG_W  = REG_W - 1;
  localparam int HI_W   = NS_W - REG_W;

  tod_addr_e        adr;
  logic             rd_frac, wr_lo, wr_hi, wr_rate, rd_any;
  logic [REG_W-1:0] rate_q, rdata_q, rdata_d;
  logic [NS_W-1:0]  ns_w, snap_w, load_ns;
  logic [FRAC_W-1:0] frac_w;
  logic [REG_W-1:0] stage_w;

  assign adr     = tod_addr_e'(addr_i);
  assign rd_any  = req_i && !we_i;
  assign rd_frac = rd_any && adr == ADR_FRAC;
  assign wr_lo   = req_i && we_i && adr == ADR_NSLO;
  assign wr_hi   = req_i && we_i && adr == ADR_NSHI;
  assign wr_rate = req_i && we_i && adr == ADR_RATE;
  assign load_ns = {wdata_i[HI_W-1:0], stage_w};

  tod_accum #(.NS_W(NS_W), .FRAC_W(FRAC_W), .STEP_NS(STEP_NS)) u_accum (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (wr_hi),
    .load_ns_i (load_ns),
    .mag_i     (rate_q[MAG_W-1:0]),
    .neg_i     (rate_q[REG_W-1]),
    .ns_o      (ns_w),
    .frac_o    (frac_w)
  );

  tod_shadow #(.NS_W(NS_W), .REG_W(REG_W)) u_shadow (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .snap_en_i  (rd_frac),
    .ns_i       (ns_w),
    .stage_en_i (wr_lo),
    .stage_d_i  (wdata_i),
    .snap_o     (snap_w),
    .stage_o    (stage_w)
  );

  always_comb begin
    unique case (adr)
      ADR_FRAC: rdata_d = frac_w;
      ADR_NSLO: rdata_d = snap_w[REG_W-1:0];
      ADR_NSHI: rdata_d = {{(REG_W-HI_W){1'b0}}, snap_w[NS_W-1:REG_W]};
      default:  rdata_d = rate_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_rate) rate_q  <= wdata_i;
      if (rd_any)  rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;

  // R4
  hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_any && adr == ADR_NSHI) |=> rdata_o[REG_W-1:HI_W] == '0);

  // R9
  rate_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rate |=> rate_q == $past(wdata_i));

  // R9
  rate_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_rate |=> $stable(rate_q));

  // R11
  rd_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_any && adr == ADR_RATE && !wr_rate) |=> rdata_o == rate_q);
endmodule

// File: tb/ptp_tod_counter_tb.sv
`timescale 1ns/1ps
module ptp_tod_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  int          q_due[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  longint base_t = 0, mag = 0, snap_ns = 0;
  int     base_l = 0;
  bit     neg = 0;

  localparam longint NS_MASK = (64'd1 << 40) - 1;
  localparam longint F_ONE   = 64'd1 << 32;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ptp_tod_counter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: results due at the falling edge after the sampling edge
  always @(negedge clk) begin
    while (q_due.size() > 0 && q_due[0] == cyc) begin
      chk(q_tag[0], rdata, q_exp[0]);
      void'(q_due.pop_front());
      void'(q_exp.pop_front());
      void'(q_tag.pop_front());
    end
  end

  task automatic bus(input bit w, input logic [1:0] a, input logic [31:0] d, output int edge_n);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    edge_n = cyc + 1;
    @(posedge clk);
    #1 req = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    int e;
    bus(1'b0, a, '0, e);
    q_due.push_back(e); q_exp.push_back(exp); q_tag.push_back(tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    int e;
    bus(1'b1, a, d, e);
  endtask

  task automatic set_rate(input logic [31:0] r);
    wr(2'd3, r);
    mag = longint'(r[30:0]);
    neg = r[31];
  endtask

  task automatic load(input logic [31:0] lo, input logic [31:0] hi);
    int e;
    wr(2'd1, lo);
    bus(1'b1, 2'd2, hi, e);
    base_t = {24'd0, hi[7:0], lo};
    base_l = e;
  endtask

  // expected state seen by a request sampled at edge e
  function automatic void model(input int e, output longint ns, output longint fr);
    longint n, tot;
    n   = longint'(e - 1 - base_l);
    tot = n * mag;
    if (!neg) begin
      fr = tot & (F_ONE - 1);
      ns = (base_t + 8 * n + (tot >> 32)) & NS_MASK;
    end else begin
      fr = (F_ONE - (tot & (F_ONE - 1))) & (F_ONE - 1);
      ns = (base_t + 8 * n - ((tot + F_ONE - 1) >> 32)) & NS_MASK;
    end
  endfunction

  task automatic snap(input string tag);
    int e;
    longint ns, fr;
    e = cyc + 1;  // next negedge drive lands on edge cyc+1 after @(negedge)
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 2'd0; wdata = '0;
    e = cyc + 1;
    @(posedge clk);
    #1 req = 1'b0;
    model(e, ns, fr);
    snap_ns = ns;
    q_due.push_back(e); q_exp.push_back(fr[31:0]); q_tag.push_back({tag, " frac"});
    rd(2'd1, snap_ns[31:0], {tag, " lo"});
    rd(2'd2, {24'd0, snap_ns[39:32]}, {tag, " hi"});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    rd(2'd1, 32'd0, "R10 shadow lo");
    rd(2'd2, 32'd0, "R10 shadow hi");
    rd(2'd3, 32'd0, "R10 rate");
    // R9 R11 rate readback with one-cycle latency
    set_rate(32'h1234_5678);
    rd(2'd3, 32'h1234_5678, "R9 R11 rate");
    set_rate(32'h0);
    // R1 nominal step
    load(32'd1000, 32'd0);
    idle(5);
    snap("R1 step");
    // R5 shadow held across idle time and later reads
    idle(20);
    rd(2'd1, snap_ns[31:0], "R5 held lo");
    rd(2'd2, {24'd0, snap_ns[39:32]}, "R5 held hi");
    snap("R5 resnap");
    // R2 positive correction
    set_rate(32'h4000_0000);
    load(32'd0, 32'd0);
    idle(9);
    snap("R2 quarter");
    set_rate(32'h7FFF_FFFF);
    load(32'h0000_0100, 32'd0);
    idle(7);
    snap("R2 max");
    // R3 negative correction
    set_rate(32'hE000_0000);
    load(32'd5000, 32'd0);
    idle(11);
    snap("R3 neg");
    set_rate(32'h8000_0001);
    load(32'd77, 32'd0);
    idle(4);
    snap("R3 tiny");
    // R4 wrap at 2^40 and hi upper bits ignored
    set_rate(32'h0);
    load(32'hFFFF_FFF0, 32'hABCD_EFFF);
    idle(3);
    snap("R4 wrap");
    // R6 staged low word does not disturb the count
    set_rate(32'h2000_0000);
    load(32'h0001_0000, 32'h0000_0012);
    wr(2'd1, 32'hDEAD_BEEF);
    idle(6);
    snap("R6 staged");
    // R7 high write commits staged low word
    begin
      int e;
      bus(1'b1, 2'd2, 32'h0000_0034, e);
      base_t = {24'd0, 8'h34, 32'hDEAD_BEEF};
      base_l = e;
    end
    idle(2);
    snap("R7 commit");
    // R8 write to fraction word ignored
    wr(2'd0, 32'hFFFF_FFFF);
    idle(3);
    snap("R8 frac write");
    idle(4);
    if (q_due.size() != 0) chk("R11 pending", 32'(q_due.size()), 32'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule